// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Policy

This block receives serial characters from a single input line. An external baud source supplies a one-cycle clock-enable tick at 32 times the bit rate. When the idle receiver sees the line low on a tick, it waits half a bit period and checks the line again. If the line is still low, the receiver accepts a start bit. It then samples eight data bits, least-significant first, followed by a parity bit and one stop bit, each in the middle of its bit period.

When the stop bit has been sampled, the assembled byte always moves into the receive buffer, including frames that carry an error. Parity, framing and overrun errors collect in sticky status flags. A completion pulse and an error pulse report each frame. A mask input decides whether an errored frame also raises the completion pulse. Software-side logic reads the buffer and the status through two read strobes.

Clearing the enable input stops reception at once and leaves the buffer and the status exactly as they were. A buffer that has not been read makes every later frame report overrun until it is read.

Top module: `uart_rx_err`

## Requirements
- R1: After reset, rx_data is 0, buf_full is 0, all three error flags are 0 and neither pulse output is high.
- R2: While rx_en is 0, the line is ignored: a complete frame driven with rx_en at 0 changes no output and raises no pulse.
- R3: A low level on the line is accepted as a start bit only if it is still low when re-sampled 16 ticks after detection. A low lasting under half a bit period returns the receiver to idle without producing a frame.
- R4: A frame is one start bit (0), 8 data bits with the least-significant bit first, one parity bit and one stop bit, each 32 ticks long. After the stop bit is sampled, rx_data holds the data byte and buf_full is 1.
- R5: A frame without error raises done_pulse for exactly one clock cycle, whatever the value of err_irq_mask.
- R6: With odd_parity at 0, the data bits together with the parity bit must hold an even number of ones. With odd_parity at 1, they must hold an odd number. A mismatch sets err_parity.
- R7: A stop-bit sample of 0 sets err_frame. The received byte is still written to rx_data.
- R8: A frame with any error raises err_pulse for one cycle. It raises done_pulse only when err_irq_mask is 0.
- R9: Clearing rx_en in the middle of a frame aborts the frame. rx_data, buf_full and the error flags keep their values, and neither pulse is raised.
- R10: A frame that completes while buf_full is 1 and buf_rd is not asserted sets err_overrun. This repeats on every further frame until the buffer is read.
- R11: A one-cycle buf_rd clears buf_full and leaves rx_data unchanged. A one-cycle stat_rd clears all three error flags. A frame completing in the same cycle takes priority over both strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Clock enable, 32 per bit period |
| rx_line | input | 1 | Serial input line, idle high, synchronous to clk |
| rx_en | input | 1 | Receive enable; 0 aborts and ignores the line |
| odd_parity | input | 1 | 0 selects even parity, 1 selects odd parity |
| err_irq_mask | input | 1 | 1 suppresses done_pulse on errored frames |
| buf_rd | input | 1 | Buffer read strobe, clears buf_full |
| stat_rd | input | 1 | Status read strobe, clears the error flags |
| rx_data | output | 8 | Receive buffer |
| buf_full | output | 1 | Buffer holds an unread byte |
| err_parity | output | 1 | Sticky parity error flag |
| err_frame | output | 1 | Sticky framing error flag |
| err_overrun | output | 1 | Sticky overrun error flag |
| done_pulse | output | 1 | One-cycle reception-complete pulse |
| err_pulse | output | 1 | One-cycle error pulse |

## Verification
The assertions assume that rx_line is already synchronous to clk and that err_irq_mask is held steady around each frame end, since the mask check looks one cycle back. They also assume that the read strobes are single-cycle pulses. The bench changes rx_line and every control only on falling clock edges, right after a tick edge, so each bit spans exactly 32 ticks. It alters the mask only while the receiver is idle and pulses each strobe for a single cycle. Ticks arrive on every second clock, so any logic that ignores the enable would show up as a changed bit timing.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

  // Parity mismatch: data_xor is the XOR of all data bits.
  // even mode: data+parity must have even ones; odd mode: odd ones.
  function automatic logic parity_bad(input logic data_xor,
                                      input logic par_bit,
                                      input logic odd_mode);
    return (data_xor ^ par_bit) != odd_mode;
  endfunction

endpackage

// File: rtl/uart_rx_bitcnt.sv
module uart_rx_bitcnt #(
  parameter int OVS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  output logic half_hit,
  output logic full_hit
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  assign half_hit = tick && (cnt == CW'(HALF - 1));
  assign full_hit = tick && (cnt == CW'(OVS - 1));
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              rx_en,
  input  logic              half_hit,
  input  logic              full_hit,
  output logic              cnt_clr,
  output logic              frame_end,
  output logic              busy,
  output logic [DATA_W-1:0] shift_q,
  output logic              par_q
);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  rx_state_t     state;
  logic [IW-1:0] bit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_idx <= '0;
      shift_q <= '0;
      par_q   <= 1'b0;
    end else if (!rx_en) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  if (tick && !line) state <= ST_START;
        ST_START: if (half_hit) begin
          state   <= line ? ST_IDLE : ST_DATA;
          bit_idx <= '0;
        end
        ST_DATA:  if (full_hit) begin
          shift_q <= {line, shift_q[DATA_W-1:1]};
          if (bit_idx == IW'(DATA_W - 1)) state <= ST_PAR;
          else bit_idx <= bit_idx + 1'b1;
        end
        ST_PAR:   if (full_hit) begin
          par_q <= line;
          state <= ST_STOP;
        end
        ST_STOP:  if (full_hit) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign cnt_clr   = !rx_en || (state == ST_IDLE) ||
                     ((state == ST_START) && half_hit) || full_hit;
  assign frame_end = rx_en && (state == ST_STOP) && full_hit;
  assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/uart_rx_result.sv
module uart_rx_result
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic [DATA_W-1:0] shift_q,
  input  logic              par_q,
  input  logic              stop_bit,
  input  logic              odd_parity,
  input  logic              err_irq_mask,
  input  logic              buf_rd,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              buf_full,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              done_pulse,
  output logic              err_pulse
);
  logic new_pe, new_fe, new_oe, any_err;

  assign new_pe  = parity_bad(^shift_q, par_q, odd_parity);
  assign new_fe  = !stop_bit;
  assign new_oe  = buf_full && !buf_rd;
  assign any_err = new_pe || new_fe || new_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      buf_full    <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
      done_pulse  <= 1'b0;
      err_pulse   <= 1'b0;
    end else begin
      done_pulse <= frame_end && (!any_err || !err_irq_mask);
      err_pulse  <= frame_end && any_err;
      if (frame_end) begin
        rx_data     <= shift_q;
        buf_full    <= 1'b1;
        err_parity  <= (err_parity  && !stat_rd) || new_pe;
        err_frame   <= (err_frame   && !stat_rd) || new_fe;
        err_overrun <= (err_overrun && !stat_rd) || new_oe;
      end else begin
        if (buf_rd) buf_full <= 1'b0;
        if (stat_rd) begin
          err_parity  <= 1'b0;
          err_frame   <= 1'b0;
          err_overrun <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_err.sv
module uart_rx_err #(
  parameter int DATA_W = 8,
  parameter int OVS    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rx_line,
  input  logic              rx_en,
  input  logic              odd_parity,
  input  logic              err_irq_mask,
  input  logic              buf_rd,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              buf_full,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              done_pulse,
  output logic              err_pulse
);
  logic              half_hit, full_hit, cnt_clr;
  logic              frame_end, rx_busy;
  logic [DATA_W-1:0] shift_q;
  logic              par_q;

  uart_rx_bitcnt #(.OVS(OVS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .clr(cnt_clr),
    .half_hit(half_hit), .full_hit(full_hit)
  );

  uart_rx_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .line(rx_line),
    .rx_en(rx_en), .half_hit(half_hit), .full_hit(full_hit),
    .cnt_clr(cnt_clr), .frame_end(frame_end), .busy(rx_busy),
    .shift_q(shift_q), .par_q(par_q)
  );

  uart_rx_result #(.DATA_W(DATA_W)) u_res (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .shift_q(shift_q),
    .par_q(par_q), .stop_bit(rx_line), .odd_parity(odd_parity),
    .err_irq_mask(err_irq_mask), .buf_rd(buf_rd), .stat_rd(stat_rd),
    .rx_data(rx_data), .buf_full(buf_full), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun),
    .done_pulse(done_pulse), .err_pulse(err_pulse)
  );
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic err_irq_mask,
  input logic buf_rd,
  input logic stat_rd,
  input logic buf_full,
  input logic err_parity,
  input logic err_frame,
  input logic err_overrun,
  input logic done_pulse,
  input logic err_pulse,
  input logic frame_end,
  input logic rx_busy
);
  AST_IGNORE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_busy); // R2
  AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> buf_full); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse); // R5
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse); // R8
  AST_MASK_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && err_pulse) |-> !$past(err_irq_mask)); // R8
  AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_en) |=> (!done_pulse && !err_pulse)); // R9
  AST_OVR_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(frame_end)); // R10
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !frame_end) |=> (!err_parity && !err_frame && !err_overrun)); // R11
  AST_BUF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && !frame_end) |=> !buf_full); // R11
endmodule

bind uart_rx_err uart_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .err_irq_mask(err_irq_mask),
  .buf_rd(buf_rd), .stat_rd(stat_rd), .buf_full(buf_full),
  .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun),
  .done_pulse(done_pulse), .err_pulse(err_pulse),
  .frame_end(frame_end), .rx_busy(rx_busy)
);

// File: tb/tb_uart_rx_err.sv
module tb_uart_rx_err;
  localparam int CLK_PERIOD = 10;
  localparam int OVS        = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic rx_line = 1'b1;
  logic rx_en = 1'b0;
  logic odd_parity = 1'b0;
  logic err_irq_mask = 1'b0;
  logic buf_rd = 1'b0;
  logic stat_rd = 1'b0;
  logic [7:0] rx_data;
  logic buf_full, err_parity, err_frame, err_overrun, done_pulse, err_pulse;

  int total = 0;
  int fails = 0;
  int done_cnt = 0;
  int err_cnt = 0;

  uart_rx_err dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_line(rx_line),
    .rx_en(rx_en), .odd_parity(odd_parity), .err_irq_mask(err_irq_mask),
    .buf_rd(buf_rd), .stat_rd(stat_rd), .rx_data(rx_data),
    .buf_full(buf_full), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun), .done_pulse(done_pulse), .err_pulse(err_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // one tick every second clock
  always @(posedge clk) baud_tick <= ~baud_tick;

  always @(posedge clk) begin
    if (done_pulse) done_cnt <= done_cnt + 1;
    if (err_pulse)  err_cnt  <= err_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!baud_tick);
    end
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    rx_line = b;
    wait_ticks(OVS);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic par_good, input logic stop);
    logic p;
    p = (^d) ^ odd_parity;
    if (!par_good) p = ~p;
    wait_ticks(1);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit(p);
    send_bit(stop);
    rx_line = 1'b1;
    wait_ticks(6);
  endtask

  task automatic pulse_buf_rd();
    buf_rd = 1'b1; @(negedge clk); buf_rd = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_stat_rd();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; @(negedge clk);
  endtask

  task automatic clear_all();
    pulse_buf_rd();
    pulse_stat_rd();
  endtask

  task automatic t_reset();
    chk("R1 rx_data", rx_data, 8'h00);
    chk("R1 buf_full", buf_full, 0);
    chk("R1 flags", {err_parity, err_frame, err_overrun}, 3'b000);
    chk("R1 pulses", {done_pulse, err_pulse}, 2'b00);
  endtask

  task automatic t_good_even();
    int d0, e0;
    d0 = done_cnt; e0 = err_cnt;
    odd_parity = 1'b0; err_irq_mask = 1'b1;
    send_frame(8'h4D, 1'b1, 1'b1);
    chk("R4 data LSB first", rx_data, 8'h4D);
    chk("R4 buf_full", buf_full, 1);
    chk("R6 even parity ok", {err_parity, err_frame, err_overrun}, 3'b000);
    chk("R5 done with mask=1", done_cnt - d0, 1);
    chk("R5 no err pulse", err_cnt - e0, 0);
    pulse_buf_rd();
    chk("R11 buf_rd clears full", buf_full, 0);
    chk("R11 buf_rd keeps data", rx_data, 8'h4D);
    err_irq_mask = 1'b0;
  endtask

  task automatic t_good_odd();
    int d0;
    d0 = done_cnt;
    odd_parity = 1'b1;
    send_frame(8'hC8, 1'b1, 1'b1);
    chk("R6 odd parity ok data", rx_data, 8'hC8);
    chk("R6 odd parity no error", err_parity, 0);
    chk("R5 done odd", done_cnt - d0, 1);
    clear_all();
    odd_parity = 1'b0;
  endtask

  task automatic t_parity_err();
    int d0, e0;
    d0 = done_cnt; e0 = err_cnt;
    err_irq_mask = 1'b0;
    send_frame(8'h1E, 1'b0, 1'b1);
    chk("R6 parity error flag", err_parity, 1);
    chk("R7 data still loaded", rx_data, 8'h1E);
    chk("R8 done when unmasked", done_cnt - d0, 1);
    chk("R8 err pulse", err_cnt - e0, 1);
    pulse_stat_rd();
    chk("R11 stat_rd clears flags", {err_parity, err_frame, err_overrun}, 3'b000);
    pulse_buf_rd();
  endtask

  task automatic t_frame_err_masked();
    int d0, e0;
    d0 = done_cnt; e0 = err_cnt;
    err_irq_mask = 1'b1;
    send_frame(8'h37, 1'b1, 1'b0);
    chk("R7 framing flag", err_frame, 1);
    chk("R7 data loaded on framing error", rx_data, 8'h37);
    chk("R8 no done when masked", done_cnt - d0, 0);
    chk("R8 err pulse masked", err_cnt - e0, 1);
    err_irq_mask = 1'b0;
    clear_all();
  endtask

  task automatic t_overrun();
    send_frame(8'h11, 1'b1, 1'b1);
    chk("R10 no overrun first", err_overrun, 0);
    send_frame(8'h22, 1'b1, 1'b1);
    chk("R10 overrun set", err_overrun, 1);
    chk("R10 newest data", rx_data, 8'h22);
    pulse_stat_rd();
    send_frame(8'h33, 1'b1, 1'b1);
    chk("R10 overrun persists", err_overrun, 1);
    clear_all();
    send_frame(8'h44, 1'b1, 1'b1);
    chk("R10 overrun gone after read", err_overrun, 0);
    chk("R10 data after read", rx_data, 8'h44);
    clear_all();
  endtask

  task automatic t_false_start();
    int d0;
    d0 = done_cnt;
    wait_ticks(1);
    rx_line = 1'b0;
    wait_ticks(6);
    rx_line = 1'b1;
    wait_ticks(OVS * 12);
    chk("R3 glitch no frame", done_cnt - d0, 0);
    chk("R3 glitch buffer empty", buf_full, 0);
    send_frame(8'h5A, 1'b1, 1'b1);
    chk("R3 frame after glitch", rx_data, 8'h5A);
    chk("R3 done after glitch", done_cnt - d0, 1);
    pulse_stat_rd();
  endtask

  task automatic t_abort();
    int d0, e0;
    d0 = done_cnt; e0 = err_cnt;
    wait_ticks(1);
    send_bit(1'b0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    rx_en = 1'b0; rx_line = 1'b1;
    wait_ticks(OVS * 8);
    chk("R9 data kept", rx_data, 8'h5A);
    chk("R9 full kept", buf_full, 1);
    chk("R9 flags kept", {err_parity, err_frame, err_overrun}, 3'b000);
    chk("R9 no pulses", (done_cnt - d0) + (err_cnt - e0), 0);
    rx_en = 1'b1;
    pulse_buf_rd();
    send_frame(8'h96, 1'b1, 1'b1);
    chk("R9 recovers", rx_data, 8'h96);
    clear_all();
  endtask

  task automatic t_disabled();
    int d0;
    d0 = done_cnt;
    rx_en = 1'b0;
    send_frame(8'hE1, 1'b0, 1'b0);
    chk("R2 ignored data", rx_data, 8'h96);
    chk("R2 ignored full", buf_full, 0);
    chk("R2 ignored flags", {err_parity, err_frame, err_overrun}, 3'b000);
    chk("R2 ignored pulses", done_cnt - d0, 0);
    rx_en = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    rx_en = 1'b1;
    t_good_even();
    t_good_odd();
    t_parity_err();
    t_frame_err_masked();
    t_overrun();
    t_false_start();
    t_abort();
    t_disabled();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule